// File: doc/BRIEF.md
# Missing-Aware Majority Voter

This block sits at a receiver and turns the values that several relays delivered into one decided value. Each relay contributes one code. The code zero means the relay's message was lost or failed its integrity check. The codes 1 up to the relay count stand for wrong but plausible values. The code one above the relay count is the correct value. Lost entries are removed before the vote. They cannot win, and they do not count toward the total that a winner must exceed half of. Because of this, a single surviving healthy relay can still carry the vote when its partners drop out.

All entries for one vote arrive together as a packed vector under a valid/ready handshake. The decision is computed combinationally, then captured in an output register when the vector is accepted. It is offered downstream under its own valid/ready pair. A new vector is accepted only when the output register is empty or is being drained in the same cycle. While downstream holds ready low, the output valid and the vote stay frozen and the input side stalls. Once a vote has been handed over, its value stays on the output pins until the next vector is accepted, so later stages can sample it at leisure.

Top module: `dmv_voter`

## Requirements
- R1: Entry k of the input vector occupies bits [k*VW +: VW], where VW = clog2(N+2). Code 0 means missing, codes 1..N are wrong values and code N+1 is the correct value. A delivered vote is always within 0..N+1.
- R2: A candidate code v in 1..N+1 wins when twice its number of occurrences exceeds the number of entries that are not 0. The winner is the vote.
- R3: When no candidate meets the R2 condition, the vote is 0.
- R4: When every entry is 0, the vote is 0.
- R5: With N=3, two entries of 0 and one entry of 4, the vote is 4.
- R6: A code above N+1 is never a candidate, but it still counts as a non-missing entry in the R2 total.
- R7: An input vector is accepted on a rising edge where in_valid and in_ready are both high. Its vote appears on out_vote, with out_valid high, after that same edge.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_vote does not change.
- R9: in_ready is high exactly when out_valid is low or out_ready is high. A vector offered while in_ready is low is ignored.
- R10: After reset, out_valid is 0, out_vote is 0 and in_ready is 1.
- R11: out_vote changes only on an accepting edge. After a handover it keeps the last vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector is offered |
| in_ready | output | 1 | Voter can take a vector this cycle |
| in_entries | input | N*VW | Packed relay codes, entry 0 in the low bits |
| out_valid | output | 1 | A vote is waiting to be taken |
| out_ready | input | 1 | Downstream takes the vote this cycle |
| out_vote | output | VW | Decided code, 0 when no majority |

## Verification
A wrong count or comparison inside the tally does not stay hidden. It shows up as a wrong out_vote on the very next cycle after the vector is accepted. The directed patterns mix missing entries, out-of-range codes and ties, so that a wrong denominator or wrong candidate set changes the decided code. A fault in the output register shows up instead in the handshake. Such a fault would make out_valid drop, or out_vote move, during a stall, or let a blocked vector overwrite the held vote. Both of these are visible within a cycle of the stall or handover.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
  // width of one relay code: codes 0..n+1
  function automatic int code_width(input int n);
    return $clog2(n + 2);
  endfunction
  // width of a count with one extra bit so the doubled count fits
  function automatic int count_width(input int n);
    return $clog2(n + 1) + 1;
  endfunction
endpackage

// File: rtl/dmv_tally.sv
module dmv_tally #(
  parameter int N  = 3,
  parameter int VW = 3,
  parameter int CW = 3
) (
  input  logic [N*VW-1:0]     entries,
  output logic [(N+1)*CW-1:0] cand_counts,
  output logic [CW-1:0]       present_cnt
);
  // occurrences of each candidate code v (slot v-1)
  for (genvar v = 1; v <= N + 1; v++) begin : g_cand
    logic [CW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int k = 0; k < N; k++) begin
        if (entries[k*VW +: VW] == VW'(v)) cnt = cnt + CW'(1);
      end
    end
    assign cand_counts[(v-1)*CW +: CW] = cnt;
  end

  // entries that are not the missing code
  always_comb begin
    present_cnt = '0;
    for (int k = 0; k < N; k++) begin
      if (entries[k*VW +: VW] != '0) present_cnt = present_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/dmv_pick.sv
module dmv_pick #(
  parameter int N  = 3,
  parameter int VW = 3,
  parameter int CW = 3
) (
  input  logic [(N+1)*CW-1:0] cand_counts,
  input  logic [CW-1:0]       present_cnt,
  output logic [VW-1:0]       winner
);
  logic [N+1:1] wins;

  for (genvar v = 1; v <= N + 1; v++) begin : g_cmp
    logic [CW-1:0] doubled;
    assign doubled  = cand_counts[(v-1)*CW +: CW] << 1;
    assign wins[v]  = (doubled > present_cnt);
  end

  // at most one candidate can exceed half; scan keeps the lowest anyway
  always_comb begin
    winner = '0;
    for (int v = N + 1; v >= 1; v--) begin
      if (wins[v]) winner = VW'(v);
    end
  end
endmodule

// File: rtl/dmv_outreg.sv
module dmv_outreg #(
  parameter int VW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] next_vote,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_vote
);
  logic          held;
  logic [VW-1:0] vote_q;
  logic          take;

  assign in_ready = !held || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      vote_q <= '0;
    end else if (take) begin
      held   <= 1'b1;
      vote_q <= next_vote;
    end else if (out_ready) begin
      held   <= 1'b0;
    end
  end

  assign out_valid = held;
  assign out_vote  = vote_q;
endmodule

// File: rtl/dmv_voter.sv
module dmv_voter #(
  parameter int N  = 3,
  parameter int VW = dmv_pkg::code_width(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N*VW-1:0] in_entries,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_vote
);
  localparam int CW = dmv_pkg::count_width(N);

  logic [(N+1)*CW-1:0] cand_counts;
  logic [CW-1:0]       present_cnt;
  logic [VW-1:0]       winner;

  dmv_tally #(.N(N), .VW(VW), .CW(CW)) u_tally (
    .entries     (in_entries),
    .cand_counts (cand_counts),
    .present_cnt (present_cnt)
  );

  dmv_pick #(.N(N), .VW(VW), .CW(CW)) u_pick (
    .cand_counts (cand_counts),
    .present_cnt (present_cnt),
    .winner      (winner)
  );

  dmv_outreg #(.VW(VW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .next_vote (winner),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vote  (out_vote)
  );
endmodule

// File: rtl/dmv_voter_chk.sv
module dmv_voter_chk #(
  parameter int N  = 3,
  parameter int VW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_vote
);
  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_vote) <= N + 1));

  assert_accept_shows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vote)));

  assert_ready_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  assert_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_vote_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_vote));
endmodule

bind dmv_voter dmv_voter_chk #(.N(N), .VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vote  (out_vote)
);

// File: tb/dmv_voter_tb.sv
`timescale 1ns/1ps
module dmv_voter_tb;
  localparam int N  = 3;
  localparam int VW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N*VW-1:0] in_entries = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] out_vote;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dmv_voter #(.N(N)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_entries (in_entries),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_vote   (out_vote)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic logic [N*VW-1:0] pack3(input int e0, input int e1, input int e2);
    return {VW'(e2), VW'(e1), VW'(e0)};
  endfunction

  // one vote with downstream always ready; checks vote and single-cycle valid
  task automatic run_vote(input int e0, input int e1, input int e2,
                          input int expected, input string req);
    @(negedge clk);
    in_entries = pack3(e0, e1, e2);
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " vote"}, out_vote, expected);
    check("R7 valid after accept", out_valid, 1);
    @(negedge clk);
    check("R7 valid drops after handover", out_valid, 0);
    check("R11 vote held after handover", out_vote, expected);
  endtask

  task automatic test_reset();
    check("R10 out_valid", out_valid, 0);
    check("R10 out_vote", out_vote, 0);
    check("R10 in_ready", in_ready, 1);
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    out_ready  = 1'b0;
    in_entries = pack3(4, 4, 4);
    in_valid   = 1'b1;
    @(negedge clk);
    in_entries = pack3(1, 1, 1);   // offered while blocked
    for (int i = 0; i < 3; i++) begin
      check("R8 valid held", out_valid, 1);
      check("R8 vote held", out_vote, 4);
      check("R9 in_ready low", in_ready, 0);
      @(negedge clk);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 blocked vector ignored", out_vote, 4);
    check("R9 valid released", out_valid, 0);
    check("R9 in_ready back", in_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_vote(4, 4, 4, 4, "R2 unanimous correct");
    run_vote(2, 2, 4, 2, "R2 wrong-value majority");
    run_vote(0, 3, 3, 3, "R2 missing dropped");
    run_vote(0, 0, 4, 4, "R5 lone survivor");
    run_vote(1, 2, 4, 0, "R3 three-way split");
    run_vote(0, 1, 4, 0, "R3 tie among present");
    run_vote(0, 0, 0, 0, "R4 all missing");
    run_vote(5, 4, 4, 4, "R6 out-of-range counted");
    run_vote(5, 5, 4, 0, "R6 out-of-range not candidate");
    run_vote(7, 0, 0, 0, "R6 only out-of-range present");
    run_vote(4, 0, 4, 4, "R1 entry positions");
    test_backpressure();
    run_vote(3, 0, 0, 3, "R2 after stall");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule